// File: doc/BRIEF.md
# Parallel-In Serial-Out Word FIFO

This block buffers 16-bit words written through a parallel port and sends them out one bit per cycle on a single serial line. Writes are qualified by a write enable. The read side moves forward on a shift enable, one bit per enabled cycle, and goes to the next stored word once all 16 bits of the current word have been sent. The current bit is always present on the serial output, so a word written into an empty buffer can be seen on the output after the write edge with no extra read cycle.

A direction input is latched while reset is held. It sets the bit order used for every word until the next reset. Four status flags come from the stored word count. Empty stops further shifting and Full stops further writes. Half-full rises above half the depth. A single almost flag covers both ends: it is set when the buffer is close to empty or close to full.

Top module: `p2s_fifo`

## Requirements
- R1: When `wr_en_i` is high and `full_o` is low, a rising clock edge stores the 16-bit `wr_data_i`. Words leave in the order they were written.
- R2: When `shift_en_i` is high and `empty_o` is low, a rising edge moves to the next bit of the current word. After the 16th bit the next word is presented.
- R3: `dir_i` is latched while `rst_ni` is low. A value of 0 sends bit 0 first and bit 15 last. A value of 1 sends bit 15 first and bit 0 last. Changes to `dir_i` after reset has been released have no effect.
- R4: After reset the buffer holds no words, `empty_o`=1, `full_o`=0, `half_o`=0 and `almost_o`=1.
- R5: While `empty_o` is high, `shift_en_i` has no effect and `ser_o` is 0. `empty_o` is high exactly when the word count is 0.
- R6: While `full_o` is high, writes are dropped and the stored data is unchanged. `full_o` is high exactly when the count equals DEPTH (256).
- R7: `half_o` is high exactly when the count is greater than DEPTH/2 (128).
- R8: `almost_o` is high exactly when the count is at most DEPTH/8-1 (31) or at least DEPTH-DEPTH/8+1 (225).
- R9: A word written into an empty buffer drives its first bit onto `ser_o` in the cycle right after the write edge, with no shift needed.
- R10: The count goes up by one on an accepted write and down by one when the last bit of a word is shifted. If both happen on the same edge, the count stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Bit order, latched during reset (1 = MSB first) |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | 16 | Parallel write word |
| shift_en_i | input | 1 | Serial shift enable |
| ser_o | output | 1 | Serial data bit |
| empty_o | output | 1 | No words stored |
| full_o | output | 1 | DEPTH words stored |
| half_o | output | 1 | More than DEPTH/2 words stored |
| almost_o | output | 1 | Close to empty or close to full |

## Verification
A fill to full with no shifting steps the count through every flag threshold. It separates an off-by-one in the half and almost limits from a correct one. Writes made while full are followed by a complete drain, which would expose any dropped word that still got stored. Long random runs with a mix of writes and shifts, once in each bit order, cover simultaneous write and word completion, writes into an empty buffer, and shifts attempted while empty. A directed case toggles the direction input after reset and confirms that the bit order set during reset is kept.

// File: rtl/p2s_pkg.sv
package p2s_pkg;
  localparam int unsigned WORD_W = 16;

  typedef struct packed {
    logic empty;
    logic full;
    logic half;
    logic almost;
  } flags_t;
endpackage

// File: rtl/p2s_store.sv
module p2s_store #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned WORD_W = p2s_pkg::WORD_W,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_ptr_i,
  output logic [WORD_W-1:0] rd_word_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wr_ptr_q <= '0;
    else if (wr_i) wr_ptr_q <= (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  // asynchronous read gives zero fall-through
  assign rd_word_o = mem_q[rd_ptr_i];
endmodule

// File: rtl/p2s_serializer.sv
module p2s_serializer #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned WORD_W = p2s_pkg::WORD_W,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned BW    = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              shift_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [AW-1:0]     rd_ptr_o,
  output logic              bit_o,
  output logic              word_done_o
);
  localparam logic [BW-1:0] TOP_IDX = BW'(WORD_W-1);

  logic          msb_first_q;
  logic [BW-1:0] idx_q;
  logic [AW-1:0] rd_ptr_q;
  logic [BW-1:0] last_idx, first_idx;

  assign first_idx   = msb_first_q ? TOP_IDX : '0;
  assign last_idx    = msb_first_q ? '0 : TOP_IDX;
  assign word_done_o = shift_i && (idx_q == last_idx);

  // bit order is latched while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msb_first_q <= dir_i;
      idx_q       <= dir_i ? TOP_IDX : '0;
      rd_ptr_q    <= '0;
    end else if (shift_i) begin
      if (word_done_o) begin
        idx_q    <= first_idx;
        rd_ptr_q <= (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + 1'b1;
      end else if (msb_first_q) begin
        idx_q <= idx_q - 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign rd_ptr_o = rd_ptr_q;
  assign bit_o    = word_i[idx_q];
endmodule

// File: rtl/p2s_flags.sv
module p2s_flags #(
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW   = $clog2(DEPTH) + 1,
  localparam int unsigned HALF = DEPTH / 2,
  localparam int unsigned AE   = DEPTH / 8 - 1,
  localparam int unsigned AF   = DEPTH - DEPTH / 8 + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inc_i,
  input  logic              dec_i,
  output p2s_pkg::flags_t   flags_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (inc_i && !dec_i) cnt_q <= cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    flags_o.empty  = (cnt_q == '0);
    flags_o.full   = (cnt_q == CW'(DEPTH));
    flags_o.half   = (cnt_q > CW'(HALF));
    flags_o.almost = (cnt_q <= CW'(AE)) || (cnt_q >= CW'(AF));
  end
endmodule

// File: rtl/p2s_fifo.sv
module p2s_fifo #(
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned WORD_W = p2s_pkg::WORD_W,
  localparam int unsigned AW     = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dir_i,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic              shift_en_i,
  output logic              ser_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              half_o,
  output logic              almost_o
);
  p2s_pkg::flags_t   flags;
  logic              wr_ok, sh_ok, word_done, raw_bit;
  logic [AW-1:0]     rd_ptr;
  logic [WORD_W-1:0] rd_word;

  assign wr_ok = wr_en_i && !flags.full;
  assign sh_ok = shift_en_i && !flags.empty;

  p2s_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
    .clk_i, .rst_ni, .wr_i(wr_ok), .wr_data_i,
    .rd_ptr_i(rd_ptr), .rd_word_o(rd_word)
  );

  p2s_serializer #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_ser (
    .clk_i, .rst_ni, .dir_i, .shift_i(sh_ok), .word_i(rd_word),
    .rd_ptr_o(rd_ptr), .bit_o(raw_bit), .word_done_o(word_done)
  );

  p2s_flags #(.DEPTH(DEPTH)) u_flags (
    .clk_i, .rst_ni, .inc_i(wr_ok), .dec_i(word_done), .flags_o(flags)
  );

  assign ser_o    = flags.empty ? 1'b0 : raw_bit;
  assign empty_o  = flags.empty;
  assign full_o   = flags.full;
  assign half_o   = flags.half;
  assign almost_o = flags.almost;
endmodule

// File: rtl/p2s_fifo_checker.sv
module p2s_fifo_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic shift_en_i,
  input logic ser_o,
  input logic empty_o,
  input logic full_o,
  input logic half_o,
  input logic almost_o
);
  assert_no_overflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !shift_en_i |=> full_o);

  assert_no_underflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && !wr_en_i |=> empty_o && !ser_o);

  assert_fall_through_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o && wr_en_i |=> !empty_o);

  assert_flag_excl_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(empty_o && full_o));

  assert_half_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> half_o);

  assert_almost_ends_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o || full_o) |-> almost_o);
endmodule

bind p2s_fifo p2s_fifo_checker u_chk (
  .clk_i, .rst_ni, .wr_en_i, .shift_en_i, .ser_o,
  .empty_o, .full_o, .half_o, .almost_o
);

// File: tb/tb_p2s_fifo.sv
module tb_p2s_fifo;
  localparam int unsigned DEPTH = 256;

  logic clk = 1'b0, rst_n = 1'b0, dir = 1'b0;
  logic wr_en = 1'b0, shift_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic ser, empty, full, half, almost;

  always #10 clk = ~clk;

  p2s_fifo #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .shift_en_i(shift_en), .ser_o(ser),
    .empty_o(empty), .full_o(full), .half_o(half), .almost_o(almost)
  );

  int total = 0, bad = 0;
  logic [15:0] q[$];
  int bpos = 0;
  bit msb = 0;

  function automatic bit exp_ser();
    if (q.size() == 0) return 1'b0;
    return msb ? q[0][15 - bpos] : q[0][bpos];
  endfunction

  function automatic bit exp_almost(int n);
    return (n <= DEPTH/8 - 1) || (n >= DEPTH - DEPTH/8 + 1);
  endfunction

  task automatic chk(string req, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0b exp=%0b n=%0d t=%0t", req, got, exp, q.size(), $time);
    end
  endtask

  task automatic check_all();
    int n = q.size();
    chk(msb ? "R3" : "R2", ser, exp_ser());
    chk("R5", empty, n == 0);
    chk("R6", full, n == DEPTH);
    chk("R7", half, n > DEPTH/2);
    chk("R8", almost, exp_almost(n));
  endtask

  // check at negedge, drive, take the edge, update the model
  task automatic step(bit w, logic [15:0] d, bit s);
    bit acc_w, acc_s;
    @(negedge clk);
    check_all();
    wr_en = w; wr_data = d; shift_en = s;
    acc_w = w && (q.size() < DEPTH);
    acc_s = s && (q.size() > 0);
    @(posedge clk);
    if (acc_s) begin
      bpos++;
      if (bpos == 16) begin void'(q.pop_front()); bpos = 0; end
    end
    if (acc_w) q.push_back(d);
    @(negedge clk);
    wr_en = 0; shift_en = 0;
  endtask

  task automatic do_reset(bit d);
    @(negedge clk);
    rst_n = 0; dir = d;
    repeat (2) @(negedge clk);
    q.delete(); bpos = 0; msb = d;
    rst_n = 1;
    dir = ~d;  // R3: must be ignored from now on
  endtask

  task automatic random_run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      int r = $urandom_range(0, 99);
      step(r < 12 || (r >= 60 && r < 70), 16'($urandom()), r >= 12);
    end
    while (q.size() > 0) step(0, 16'h0, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    do_reset(0);
    @(negedge clk);
    chk("R4", empty, 1'b1); chk("R4", full, 1'b0);
    chk("R4", half, 1'b0);  chk("R4", almost, 1'b1);

    // R9: zero fall-through, LSB first
    step(1, 16'hA5C3, 0);
    chk("R9", ser, 1'b1);
    for (int i = 0; i < 15; i++) step(0, 16'h0, 1);
    // R10: write together with word completion keeps count at 1
    step(1, 16'h0002, 1);
    chk("R10", empty, 1'b0);
    chk("R1", ser, 1'b0);
    step(0, 16'h0, 1);
    chk("R1", ser, 1'b1);
    while (q.size() > 0) step(0, 16'h0, 1);

    // R5: shifts while empty do nothing
    for (int i = 0; i < 4; i++) step(0, 16'h0, 1);

    // fill through every threshold, R6 blocked writes, then drain
    for (int i = 0; i < DEPTH; i++) step(1, 16'(i * 16'h9E37 + 1), 0);
    chk("R6", full, 1'b1);
    for (int i = 0; i < 3; i++) step(1, 16'hFFFF, 0);
    while (q.size() > 0) step(0, 16'h0, 1);

    random_run(3000);

    // MSB-first
    do_reset(1);
    step(1, 16'h8001, 0);
    chk("R3", ser, 1'b1);
    step(0, 16'h0, 1);
    chk("R3", ser, 1'b0);
    while (q.size() > 0) step(0, 16'h0, 1);
    random_run(3000);
    step(0, 16'h0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule